// File: doc/BRIEF.md
# Edge-Latching Chained Interrupt Controller

This block collects rising edges from a set of interrupt sources into a sticky pending register, gates the pending bits with an enable register, and drives one combined interrupt line towards a parent controller. An event is recorded whether or not its source is enabled. Software therefore clears any stale event before it enables a source, so that old activity does not raise the line.

Software reaches the two registers over a small 32-bit register bus. Writes complete in the cycle of the request. A read returns its data one cycle after the request, with a valid strobe. A pending bit is acknowledged by writing 0 to its position in the pending register. Writing 1 to a position leaves that bit alone. A single write of all zeros therefore clears every pending event.

The bus port uses a two-state read sequencer:
- `BUS_IDLE` is the state after reset and whenever no read is in flight. A read request moves it to `BUS_RESP` (transition "accept read").
- In `BUS_RESP` the read data is presented with `bus_rvalid_o` high. Another read request keeps it in `BUS_RESP` (transition "chain read"). Otherwise it returns to `BUS_IDLE` (transition "retire").

Top module: `eirq_bridge_ctrl`

## Requirements
- R1: After reset, the pending register (byte offset 0x0) and the enable register (byte offset 0x4) both read 0, `irq_o` is low and `bus_rvalid_o` is low.
- R2: A source whose input was 0 at one clock edge and is 1 at the next sets its pending bit at that second edge. The bit stays set after the input falls. An input held high sets the bit only once.
- R3: A pending bit is set by an edge even while its enable bit is 0.
- R4: A write to offset 0x0 clears each pending bit whose data bit is 0 and leaves unchanged each pending bit whose data bit is 1.
- R5: A write of 0x00000000 to offset 0x0 clears every pending bit.
- R6: When an edge on a source and a write that clears that source's pending bit fall at the same clock edge, the bit is set after that edge.
- R7: The enable register at offset 0x4 is written with the full data word and reads back the written value in its implemented positions. An enable bit of 1 enables the source and 0 disables it.
- R8: `irq_o` is high exactly when some bit is 1 in both the pending and the enable register. It follows register changes with no added cycle.
- R9: Only source positions below `NUM_SRC` are implemented. The other positions read 0 in both registers, and they ignore both writes and input edges.
- R10: A read request at a clock edge gives `bus_rvalid_o` high for the following cycle. `bus_rdata_o` then holds the register value as it stood before that edge. Any other offset reads 0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | DATA_W | Interrupt source inputs, edge sensitive |
| bus_req_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid while `bus_rvalid_o` is high |
| bus_rvalid_o | output | 1 | Read data valid |
| irq_o | output | 1 | Combined interrupt line to the parent controller |

## Verification
The bench builds the block with `NUM_SRC` set to 24, so the eight top positions are unimplemented. This lets it drive edges and all-ones writes into those positions and observe that they read back as 0 in both registers. The implemented positions then cover collisions between an edge and a clear, held-high inputs, masked latching and a stale-clear-then-enable sequence. Back-to-back reads exercise the chain-read transition of the sequencer.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_t;

    localparam int unsigned PEND_OFS = 0;
    localparam int unsigned ENAB_OFS = 4;

endpackage

// File: rtl/eirq_edge_detect.sv
module eirq_edge_detect #(
    parameter int unsigned W   = 32,
    parameter int unsigned NUM = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig_i,
    output logic [W-1:0] rise_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i < NUM) begin : g_impl
            logic prev_q;
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= sig_i[i];
            end
            assign rise_o[i] = sig_i[i] & ~prev_q;
        end else begin : g_none
            assign rise_o[i] = 1'b0;
        end
    end

endmodule

// File: rtl/eirq_cause_reg.sv
module eirq_cause_reg #(
    parameter int unsigned W   = 32,
    parameter int unsigned NUM = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rise_i,
    input  logic         clr_en_i,
    input  logic [W-1:0] clr_data_i,
    output logic [W-1:0] pend_o
);

    logic [W-1:0] pend_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i < NUM) begin : g_impl
            logic keep;
            assign keep = ~clr_en_i | clr_data_i[i];
            always_ff @(posedge clk) begin
                if (!rst_n) pend_q[i] <= 1'b0;
                else        pend_q[i] <= (pend_q[i] & keep) | rise_i[i];
            end
        end else begin : g_none
            assign pend_q[i] = 1'b0;
        end
    end

    assign pend_o = pend_q;

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i != '0) |=> ((pend_q & $past(rise_i)) == $past(rise_i))); // R2

    AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en_i && ((rise_i & ~clr_data_i) != '0))
        |=> ((pend_q & $past(rise_i & ~clr_data_i)) == $past(rise_i & ~clr_data_i))); // R6

    AST_ONES_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_i |=> ((pend_q & $past(pend_q & clr_data_i)) == $past(pend_q & clr_data_i))); // R4

    AST_ZERO_CLEARS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en_i && clr_data_i == '0 && rise_i == '0) |=> (pend_q == '0)); // R5

endmodule

// File: rtl/eirq_bus_if.sv
module eirq_bus_if
    import eirq_pkg::*;
#(
    parameter int unsigned W      = 32,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [W-1:0]      pend_i,
    input  logic [W-1:0]      enab_i,
    output logic              pend_wr_o,
    output logic              enab_wr_o,
    output logic [W-1:0]      rdata_o,
    output logic              rvalid_o
);

    localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(PEND_OFS);
    localparam logic [ADDR_W-1:0] ENAB_A = ADDR_W'(ENAB_OFS);

    bus_state_t state_q, state_d;
    logic       rd_req;
    logic [W-1:0] rdata_q, rsel;

    assign rd_req = req_i & ~we_i;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (rd_req) state_d = BUS_RESP;
            BUS_RESP: if (!rd_req) state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        if      (addr_i == PEND_A) rsel = pend_i;
        else if (addr_i == ENAB_A) rsel = enab_i;
        else                       rsel = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_req) rdata_q <= rsel;
    end

    always_comb begin
        rvalid_o  = (state_q == BUS_RESP);
        rdata_o   = rdata_q;
        pend_wr_o = req_i & we_i & (addr_i == PEND_A);
        enab_wr_o = req_i & we_i & (addr_i == ENAB_A);
    end

    AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rvalid_o); // R10

    AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rvalid_o); // R10

endmodule

// File: rtl/eirq_bridge_ctrl.sv
module eirq_bridge_ctrl #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned ADDR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] src_i,
    input  logic              bus_req_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              bus_rvalid_o,
    output logic              irq_o
);

    localparam logic [DATA_W-1:0] IMPL =
        (NUM_SRC >= DATA_W) ? {DATA_W{1'b1}} : ((DATA_W'(1) << NUM_SRC) - DATA_W'(1));

    logic [DATA_W-1:0] rise, pend, enab_q;
    logic              pend_wr, enab_wr;

    eirq_edge_detect #(.W(DATA_W), .NUM(NUM_SRC)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (src_i),
        .rise_o (rise)
    );

    eirq_cause_reg #(.W(DATA_W), .NUM(NUM_SRC)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (rise),
        .clr_en_i   (pend_wr),
        .clr_data_i (bus_wdata_i),
        .pend_o     (pend)
    );

    eirq_bus_if #(.W(DATA_W), .ADDR_W(ADDR_W)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (bus_req_i),
        .we_i      (bus_we_i),
        .addr_i    (bus_addr_i),
        .pend_i    (pend),
        .enab_i    (enab_q),
        .pend_wr_o (pend_wr),
        .enab_wr_o (enab_wr),
        .rdata_o   (bus_rdata_o),
        .rvalid_o  (bus_rvalid_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)       enab_q <= '0;
        else if (enab_wr) enab_q <= bus_wdata_i & IMPL;
    end

    assign irq_o = |(pend & enab_q);

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (enab_q != '0)); // R8

    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend != '0)); // R8

endmodule

// File: tb/eirq_bridge_ctrl_tb_top.sv
module eirq_bridge_ctrl_tb_top;

    localparam int unsigned DW  = 32;
    localparam int unsigned NS  = 24;
    localparam int unsigned AW  = 4;
    localparam logic [31:0] IMPL = 32'h00FF_FFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] src_i = '0;
    logic          bus_req_i = 1'b0;
    logic          bus_we_i = 1'b0;
    logic [AW-1:0] bus_addr_i = '0;
    logic [DW-1:0] bus_wdata_i = '0;
    logic [DW-1:0] bus_rdata_o;
    logic          bus_rvalid_o;
    logic          irq_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    eirq_bridge_ctrl #(.DATA_W(DW), .NUM_SRC(NS), .ADDR_W(AW)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_i        (src_i),
        .bus_req_i    (bus_req_i),
        .bus_we_i     (bus_we_i),
        .bus_addr_i   (bus_addr_i),
        .bus_wdata_i  (bus_wdata_i),
        .bus_rdata_o  (bus_rdata_o),
        .bus_rvalid_o (bus_rvalid_o),
        .irq_o        (irq_o)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_req_i = 1'b0; bus_we_i = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
        @(negedge clk);
        bus_req_i = 1'b0;
        chk("R10 rvalid", 32'(bus_rvalid_o), 32'd1);
        d = bus_rdata_o;
    endtask

    task automatic pulse(input logic [31:0] bits);
        @(negedge clk); src_i = src_i | bits;
        @(negedge clk); src_i = src_i & ~bits;
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R1 irq", 32'(irq_o), 32'd0);
        chk("R1 rvalid", 32'(bus_rvalid_o), 32'd0);
        rd(4'h0, v); chk("R1 pending", v, 32'd0);
        rd(4'h4, v); chk("R1 enable", v, 32'd0);
    endtask

    task automatic t_masked_latch;
        logic [31:0] v;
        pulse(32'h0000_0021);
        chk("R3 irq low while disabled", 32'(irq_o), 32'd0);
        rd(4'h0, v); chk("R2 R3 sticky latch", v, 32'h0000_0021);
    endtask

    task automatic t_ack_and_stale;
        logic [31:0] v;
        wr(4'h0, ~32'h0000_0001);
        rd(4'h0, v); chk("R4 zero clears, one keeps", v, 32'h0000_0020);
        wr(4'h0, 32'h0);
        rd(4'h0, v); chk("R5 clear all", v, 32'h0);
        wr(4'h4, 32'h0000_0021);
        chk("R8 no irq after stale clear", 32'(irq_o), 32'd0);
        rd(4'h4, v); chk("R7 enable readback", v, 32'h0000_0021);
    endtask

    task automatic t_irq;
        @(negedge clk); src_i[5] = 1'b1;
        @(negedge clk);
        chk("R8 irq rises with pending", 32'(irq_o), 32'd1);
        src_i[5] = 1'b0;
        wr(4'h0, ~32'h0000_0020);
        chk("R8 irq falls on ack", 32'(irq_o), 32'd0);
        pulse(32'h0000_0100);
        chk("R7 disabled source no irq", 32'(irq_o), 32'd0);
        wr(4'h0, 32'h0);
    endtask

    task automatic t_held_high;
        logic [31:0] v;
        @(negedge clk); src_i[2] = 1'b1;
        repeat (2) @(negedge clk);
        wr(4'h0, 32'h0);
        repeat (2) @(negedge clk);
        rd(4'h0, v); chk("R2 held level sets once", v, 32'h0);
        src_i[2] = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_collision;
        logic [31:0] v;
        @(negedge clk);
        src_i[3] = 1'b1;
        bus_req_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = 4'h0; bus_wdata_i = 32'h0;
        @(negedge clk);
        bus_req_i = 1'b0; bus_we_i = 1'b0; src_i[3] = 1'b0;
        rd(4'h0, v); chk("R6 edge beats clear", v, 32'h0000_0008);
        wr(4'h0, 32'h0);
    endtask

    task automatic t_unimpl;
        logic [31:0] v;
        pulse(32'hFF00_0000);
        rd(4'h0, v); chk("R9 upper edges ignored", v, 32'h0);
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h4, v); chk("R9 upper enable reads 0", v, IMPL);
        wr(4'h0, 32'h0);
    endtask

    task automatic t_other_addr;
        logic [31:0] v, w;
        wr(4'h8, 32'h0);
        rd(4'h4, v); chk("R10 stray write ignored", v, IMPL);
        rd(4'hC, v); chk("R10 unmapped reads 0", v, 32'h0);
        @(negedge clk);
        bus_req_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = 4'h4;
        @(negedge clk);
        bus_addr_i = 4'h0;
        v = bus_rdata_o;
        @(negedge clk);
        bus_req_i = 1'b0;
        w = bus_rdata_o;
        chk("R10 chained read first", v, IMPL);
        chk("R10 chained read second", w, 32'h0);
        @(negedge clk);
        chk("R10 rvalid drops", 32'(bus_rvalid_o), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_masked_latch;
        t_ack_and_stale;
        t_irq;
        t_held_high;
        t_collision;
        t_unimpl;
        t_other_addr;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule